// File: doc/BRIEF.md
# Floating-Point Exponent Unit with Range Checker

This block handles the exponent half of single- and double-precision floating-point arithmetic on a 12-bit datapath. Exponents enter zero-extended to 12 bits. Single-precision exponents are 8 bits wide with a bias of 127, and double-precision exponents are 11 bits wide with a bias of 1023.

Each operation picks its two adder operands through separate multiplexers. The first operand is either the incoming exponent or the previous result, fed back from the result register. The second operand is either the incoming value or a bias constant that depends on the precision. A carry-select adder then produces one of four results:

- the difference of two exponents, together with the pre-alignment shift amount that follows from it;
- the sum of two exponents;
- a post-normalization update of the previous result by a signed adjustment;
- the removal of the bias from an exponent.

The top bit of the 12-bit result is the overflow bit for additions and the sign bit for every other operation. In the same cycle that the adder result forms, a range checker derives six condition flags from it. The result, the shift amount and the flags are all captured together on the next clock edge.

The surrounding floating-point pipeline asserts `opValid` with an operation code for one cycle per operation. It reads back the result, the shift amount and the flags while `resValid` is high. Mantissa handling, unpacking, repacking and rounding lie outside this block.

Top module: `fpExpUnit`

## Requirements
- R1: An operation presented with `opValid` high at a rising clock edge drives `result`, `shiftAmt` and all flags from that edge onward. `resValid` is high in exactly the cycles that follow an edge at which `opValid` was high.
- R2: Operation code 2'b00 (subtract) gives `result` = `expA` - `expB` modulo 4096. It also gives `shiftAmt` = the absolute difference, saturated at 31 when `isDouble`=0 and at 63 when `isDouble`=1. Every other operation code gives `shiftAmt` = 0.
- R3: Operation code 2'b01 (add) gives `result` = `expA` + `expB`. For this operation bit 11 of the result marks overflow, not sign.
- R4: Operation code 2'b10 (normalize) gives `result` = previous `result` + `expB` modulo 4096, with `expB` read as a signed 12-bit adjustment. `expA` is not used.
- R5: Operation code 2'b11 (unbias) gives `result` = `expA` - 127 when `isDouble`=0 and `expA` - 1023 when `isDouble`=1, modulo 4096.
- R6: While `opValid` is low, `result`, `shiftAmt` and all flags keep their values, whatever happens on the data inputs.
- R7: `underflow` is set when the result is zero, or when bit 11 is set for any operation other than add.
- R8: `ovfSingle` is set when the result is at least 255 with bit 11 clear. `ovfDouble` is set when the result is at least 2047 with bit 11 clear. Both are also set when an add sets bit 11.
- R9: `isOne` is set exactly when the result equals 1. `isZero` is set exactly when the result equals 0.
- R10: `cvtLimit` is set when bit 11 is clear and the result is at least the integer width (32 when `cvtLong`=0, 64 when `cvtLong`=1). It is also set when an add sets bit 11.
- R11: After reset, `resValid`, `result`, `shiftAmt` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Starts one operation at this edge |
| opCode | input | 2 | 00 subtract, 01 add, 10 normalize, 11 unbias |
| isDouble | input | 1 | Selects double precision (bias and shift saturation) |
| cvtLong | input | 1 | Destination integer width for the limit check: 0 = 32, 1 = 64 |
| expA | input | 12 | First unpacked exponent |
| expB | input | 12 | Second unpacked exponent, or the signed adjustment for normalize |
| resValid | output | 1 | Result and flags hold a fresh operation |
| result | output | 12 | Registered adder result |
| shiftAmt | output | 6 | Saturated pre-alignment shift amount |
| underflow | output | 1 | Result is zero or negative |
| ovfSingle | output | 1 | Single-precision exponent overflow |
| ovfDouble | output | 1 | Double-precision exponent overflow |
| isOne | output | 1 | Result equals one |
| isZero | output | 1 | Result equals zero |
| cvtLimit | output | 1 | Exponent too large for the integer conversion |

## Verification
The assertions check relations that must hold on every cycle:

- `resValid` follows `opValid` one edge later.
- State is held while no operation is issued.
- The shift amount stays under its precision limit and is zero outside subtraction.
- The flags stay consistent with one another: double overflow implies single overflow and the limit flag, and zero implies underflow while excluding one.

Only the bench scenarios can show the arithmetic values themselves. These are the wrap of negative differences, the feedback path across consecutive normalize steps, the bias removal per precision, and each flag at its exact threshold: 254/255, 2047, 31/32 and 63/64.

// File: rtl/fpExpPkg.sv
package fpExpPkg;

  localparam int EXP_W   = 12;
  localparam int SHIFT_W = 6;
  localparam int BLK_W   = 4;

  localparam int SP_BIAS   = 127;
  localparam int DP_BIAS   = 1023;
  localparam int SP_MAXEXP = 255;
  localparam int DP_MAXEXP = 2047;
  localparam int SP_SHMAX  = 31;
  localparam int DP_SHMAX  = 63;
  localparam int INT_NARROW = 32;
  localparam int INT_WIDE   = 64;

  typedef enum logic [1:0] {
    OP_SUB    = 2'b00,
    OP_ADD    = 2'b01,
    OP_NORM   = 2'b10,
    OP_UNBIAS = 2'b11
  } expOp_e;

  typedef enum logic {
    SELA_IN = 1'b0,
    SELA_FB = 1'b1
  } selA_e;

  typedef enum logic {
    SELB_IN   = 1'b0,
    SELB_BIAS = 1'b1
  } selB_e;

  typedef struct packed {
    selA_e selA;
    selB_e selB;
    logic  invB;
    logic  load;
    logic  msbIsOvf;
    logic  shiftEn;
  } expCtrl_t;

  typedef struct packed {
    logic underflow;
    logic ovfSingle;
    logic ovfDouble;
    logic isOne;
    logic isZero;
    logic cvtLimit;
  } expFlags_t;

endpackage

// File: rtl/fpExpAdder.sv
module fpExpAdder #(
  parameter int W   = 12,
  parameter int BLK = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  localparam int NBLK = W / BLK;

  logic [NBLK:0] carry;

  assign carry[0] = cin;

  for (genvar g = 0; g < NBLK; g++) begin : gBlk
    if (g == 0) begin : gRipple
      logic [BLK:0] full;
      assign full = (BLK+1)'(a[BLK-1:0]) + (BLK+1)'(b[BLK-1:0]) + (BLK+1)'(carry[0]);
      assign sum[BLK-1:0] = full[BLK-1:0];
      assign carry[1]     = full[BLK];
    end else begin : gSelect
      logic [BLK:0] withC0;
      logic [BLK:0] withC1;
      assign withC0 = (BLK+1)'(a[g*BLK +: BLK]) + (BLK+1)'(b[g*BLK +: BLK]);
      assign withC1 = (BLK+1)'(a[g*BLK +: BLK]) + (BLK+1)'(b[g*BLK +: BLK]) + (BLK+1)'(1);
      assign sum[g*BLK +: BLK] = carry[g] ? withC1[BLK-1:0] : withC0[BLK-1:0];
      assign carry[g+1]        = carry[g] ? withC1[BLK]     : withC0[BLK];
    end
  end
endmodule

// File: rtl/fpExpRange.sv
module fpExpRange
  import fpExpPkg::*;
#(
  parameter int W = EXP_W
) (
  input  logic [W-1:0] value,
  input  logic         msbIsOvf,
  input  logic         cvtLong,
  output expFlags_t    flags
);
  logic topBit;
  logic ovfBit;
  logic negBit;
  logic posVal;
  logic zeroVal;
  logic [W-1:0] intLim;

  always_comb begin
    topBit  = value[W-1];
    ovfBit  = topBit & msbIsOvf;
    negBit  = topBit & ~msbIsOvf;
    posVal  = ~topBit;
    zeroVal = (value == '0);
    intLim  = cvtLong ? W'(INT_WIDE) : W'(INT_NARROW);

    flags.underflow = negBit | zeroVal;
    flags.ovfSingle = ovfBit | (posVal & (value >= W'(SP_MAXEXP)));
    flags.ovfDouble = ovfBit | (posVal & (value >= W'(DP_MAXEXP)));
    flags.isOne     = (value == W'(1));
    flags.isZero    = zeroVal;
    flags.cvtLimit  = ovfBit | (posVal & (value >= intLim));
  end
endmodule

// File: rtl/fpExpCtrl.sv
module fpExpCtrl
  import fpExpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opCode,
  output expCtrl_t   ctrl,
  output logic       resValid
);
  expOp_e opDec;

  always_comb begin
    opDec         = expOp_e'(opCode);
    ctrl.selA     = SELA_IN;
    ctrl.selB     = SELB_IN;
    ctrl.invB     = 1'b0;
    ctrl.load     = opValid;
    ctrl.msbIsOvf = 1'b0;
    ctrl.shiftEn  = 1'b0;
    unique case (opDec)
      OP_SUB: begin
        ctrl.invB    = 1'b1;
        ctrl.shiftEn = 1'b1;
      end
      OP_ADD: begin
        ctrl.msbIsOvf = 1'b1;
      end
      OP_NORM: begin
        ctrl.selA = SELA_FB;
      end
      OP_UNBIAS: begin
        ctrl.selB = SELB_BIAS;
        ctrl.invB = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= opValid;
  end
endmodule

// File: rtl/fpExpDatapath.sv
module fpExpDatapath
  import fpExpPkg::*;
#(
  parameter int W   = EXP_W,
  parameter int SW  = SHIFT_W,
  parameter int BLK = BLK_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  expCtrl_t      ctrl,
  input  logic          isDouble,
  input  logic          cvtLong,
  input  logic [W-1:0]  expA,
  input  logic [W-1:0]  expB,
  output logic [W-1:0]  result,
  output logic [SW-1:0] shiftAmt,
  output expFlags_t     flags
);
  logic [W-1:0]  resultQ;
  logic [SW-1:0] shiftQ;
  expFlags_t     flagsQ;

  logic [W-1:0]  opA;
  logic [W-1:0]  opBRaw;
  logic [W-1:0]  opB;
  logic [W-1:0]  biasConst;
  logic [W-1:0]  sum;
  logic [W-1:0]  absDiff;
  logic [W-1:0]  shLim;
  logic [SW-1:0] shSat;
  expFlags_t     flagsD;

  // constant generator
  assign biasConst = isDouble ? W'(DP_BIAS) : W'(SP_BIAS);

  // operand and feedback muxes
  always_comb begin
    opA    = (ctrl.selA == SELA_FB) ? resultQ : expA;
    opBRaw = (ctrl.selB == SELB_BIAS) ? biasConst : expB;
    opB    = ctrl.invB ? ~opBRaw : opBRaw;
  end

  fpExpAdder #(.W(W), .BLK(BLK)) i_adder (
    .a   (opA),
    .b   (opB),
    .cin (ctrl.invB),
    .sum (sum)
  );

  // shift amount from the difference
  always_comb begin
    absDiff = sum[W-1] ? (~sum + W'(1)) : sum;
    shLim   = isDouble ? W'(DP_SHMAX) : W'(SP_SHMAX);
    shSat   = (absDiff > shLim) ? shLim[SW-1:0] : absDiff[SW-1:0];
  end

  fpExpRange #(.W(W)) i_range (
    .value    (sum),
    .msbIsOvf (ctrl.msbIsOvf),
    .cvtLong  (cvtLong),
    .flags    (flagsD)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      shiftQ  <= '0;
      flagsQ  <= '0;
    end else if (ctrl.load) begin
      resultQ <= sum;
      shiftQ  <= ctrl.shiftEn ? shSat : '0;
      flagsQ  <= flagsD;
    end
  end

  assign result   = resultQ;
  assign shiftAmt = shiftQ;
  assign flags    = flagsQ;
endmodule

// File: rtl/fpExpUnit.sv
module fpExpUnit
  import fpExpPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [1:0]         opCode,
  input  logic               isDouble,
  input  logic               cvtLong,
  input  logic [EXP_W-1:0]   expA,
  input  logic [EXP_W-1:0]   expB,
  output logic               resValid,
  output logic [EXP_W-1:0]   result,
  output logic [SHIFT_W-1:0] shiftAmt,
  output logic               underflow,
  output logic               ovfSingle,
  output logic               ovfDouble,
  output logic               isOne,
  output logic               isZero,
  output logic               cvtLimit
);
  expCtrl_t  ctrl;
  expFlags_t flags;

  fpExpCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .ctrl     (ctrl),
    .resValid (resValid)
  );

  fpExpDatapath #(.W(EXP_W), .SW(SHIFT_W), .BLK(BLK_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .isDouble (isDouble),
    .cvtLong  (cvtLong),
    .expA     (expA),
    .expB     (expB),
    .result   (result),
    .shiftAmt (shiftAmt),
    .flags    (flags)
  );

  assign underflow = flags.underflow;
  assign ovfSingle = flags.ovfSingle;
  assign ovfDouble = flags.ovfDouble;
  assign isOne     = flags.isOne;
  assign isZero    = flags.isZero;
  assign cvtLimit  = flags.cvtLimit;
endmodule

// File: rtl/fpExpUnitSva.sv
module fpExpUnitSva
  import fpExpPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               opValid,
  input logic [1:0]         opCode,
  input logic               isDouble,
  input logic               resValid,
  input logic [EXP_W-1:0]   result,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic               underflow,
  input logic               ovfSingle,
  input logic               ovfDouble,
  input logic               isOne,
  input logic               isZero,
  input logic               cvtLimit
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid == $past(opValid));

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(result) && $stable(shiftAmt) && $stable(underflow) && $stable(cvtLimit)));

  // R2
  shift_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !isDouble) |=> (shiftAmt <= SHIFT_W'(SP_SHMAX)));

  // R2
  shift_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode != 2'b00) |=> (shiftAmt == '0));

  // R8
  ovf_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfDouble |-> (ovfSingle && cvtLimit));

  // R9
  zero_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    isZero |-> (underflow && !isOne));
endmodule

bind fpExpUnit fpExpUnitSva i_sva (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .isDouble  (isDouble),
  .resValid  (resValid),
  .result    (result),
  .shiftAmt  (shiftAmt),
  .underflow (underflow),
  .ovfSingle (ovfSingle),
  .ovfDouble (ovfDouble),
  .isOne     (isOne),
  .isZero    (isZero),
  .cvtLimit  (cvtLimit)
);

// File: tb/test_fpExpUnit.sv
`timescale 1ns/1ps
module test_fpExpUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic        isDouble = 1'b0;
  logic        cvtLong = 1'b0;
  logic [11:0] expA = '0;
  logic [11:0] expB = '0;
  logic        resValid;
  logic [11:0] result;
  logic [5:0]  shiftAmt;
  logic        underflow, ovfSingle, ovfDouble, isOne, isZero, cvtLimit;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fpExpUnit i_fpExpUnit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .isDouble(isDouble), .cvtLong(cvtLong), .expA(expA), .expB(expB),
    .resValid(resValid), .result(result), .shiftAmt(shiftAmt),
    .underflow(underflow), .ovfSingle(ovfSingle), .ovfDouble(ovfDouble),
    .isOne(isOne), .isZero(isZero), .cvtLimit(cvtLimit)
  );

  // {op, dbl, lng, a, b, expected result, expected shift}
  localparam int NV = 23;
  localparam logic [45:0] VECS [0:NV-1] = '{
    {2'd0, 1'b0, 1'b0, 12'd130,  12'd127,  12'd3,    6'd3 },
    {2'd0, 1'b0, 1'b0, 12'd10,   12'd200,  12'd3906, 6'd31},
    {2'd0, 1'b1, 1'b0, 12'd1000, 12'd950,  12'd50,   6'd50},
    {2'd0, 1'b1, 1'b0, 12'd100,  12'd1100, 12'd3096, 6'd63},
    {2'd0, 1'b1, 1'b0, 12'd5,    12'd5,    12'd0,    6'd0 },
    {2'd1, 1'b0, 1'b0, 12'd200,  12'd100,  12'd300,  6'd0 },
    {2'd1, 1'b0, 1'b0, 12'd2000, 12'd100,  12'd2100, 6'd0 },
    {2'd3, 1'b0, 1'b0, 12'd127,  12'd0,    12'd0,    6'd0 },
    {2'd3, 1'b0, 1'b0, 12'd128,  12'd0,    12'd1,    6'd0 },
    {2'd2, 1'b0, 1'b0, 12'd0,    12'd4095, 12'd0,    6'd0 },
    {2'd3, 1'b1, 1'b1, 12'd1086, 12'd0,    12'd63,   6'd0 },
    {2'd3, 1'b1, 1'b1, 12'd1087, 12'd0,    12'd64,   6'd0 },
    {2'd3, 1'b1, 1'b0, 12'd1055, 12'd0,    12'd32,   6'd0 },
    {2'd2, 1'b1, 1'b0, 12'd0,    12'd5,    12'd37,   6'd0 },
    {2'd2, 1'b1, 1'b0, 12'd0,    12'd4048, 12'd4085, 6'd0 },
    {2'd0, 1'b0, 1'b0, 12'd254,  12'd0,    12'd254,  6'd31},
    {2'd0, 1'b0, 1'b0, 12'd255,  12'd0,    12'd255,  6'd31},
    {2'd1, 1'b1, 1'b0, 12'd2047, 12'd0,    12'd2047, 6'd0 },
    {2'd3, 1'b1, 1'b0, 12'd0,    12'd0,    12'd3073, 6'd0 },
    {2'd1, 1'b0, 1'b0, 12'd0,    12'd0,    12'd0,    6'd0 },
    {2'd0, 1'b1, 1'b0, 12'd0,    12'd63,   12'd4033, 6'd63},
    {2'd0, 1'b0, 1'b0, 12'd31,   12'd0,    12'd31,   6'd31},
    {2'd0, 1'b0, 1'b0, 12'd0,    12'd32,   12'd4064, 6'd31}
  };

  // flag order {underflow, ovfSingle, ovfDouble, isOne, isZero, cvtLimit}
  function automatic logic [5:0] refFlags(logic [1:0] op, logic [11:0] r, logic lng);
    logic ovb, neg, pos;
    int   lim;
    ovb = r[11] && (op == 2'd1);
    neg = r[11] && (op != 2'd1);
    pos = !r[11];
    lim = lng ? 64 : 32;
    return {neg || (r == 0),
            ovb || (pos && r >= 255),
            ovb || (pos && r >= 2047),
            r == 1,
            r == 0,
            ovb || (pos && int'(r) >= lim)};
  endfunction

  function automatic string reqOf(logic [1:0] op);
    case (op)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] curFlags();
    return {underflow, ovfSingle, ovfDouble, isOne, isZero, cvtLimit};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [11:0] heldRes;
    logic [5:0]  heldSh;
    logic [5:0]  heldFl;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 resValid", 32'(resValid), 0);
    chk("R11 result", 32'(result), 0);
    chk("R11 shiftAmt", 32'(shiftAmt), 0);
    chk("R11 flags", 32'(curFlags()), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  vOp;
      logic        vDbl, vLng;
      logic [11:0] vA, vB, vRes;
      logic [5:0]  vSh;
      {vOp, vDbl, vLng, vA, vB, vRes, vSh} = VECS[i];
      opValid = 1'b1; opCode = vOp; isDouble = vDbl; cvtLong = vLng;
      expA = vA; expB = vB;
      @(negedge clk);
      chk({reqOf(vOp), " result"}, 32'(result), 32'(vRes));
      chk({reqOf(vOp), " shiftAmt"}, 32'(shiftAmt), 32'(vSh));
      chk("R7 R8 R9 R10 flags", 32'(curFlags()), 32'(refFlags(vOp, vRes, vLng)));
      chk("R1 resValid", 32'(resValid), 1);
    end

    // R6 and R1: idle cycles hold state while inputs move
    heldRes = result; heldSh = shiftAmt; heldFl = curFlags();
    opValid = 1'b0; opCode = 2'd1; expA = 12'd77; expB = 12'd900; isDouble = 1'b1;
    @(negedge clk);
    chk("R1 resValid low", 32'(resValid), 0);
    expA = 12'd5; expB = 12'd4000; opCode = 2'd2;
    repeat (3) @(negedge clk);
    chk("R6 result held", 32'(result), 32'(heldRes));
    chk("R6 shift held", 32'(shiftAmt), 32'(heldSh));
    chk("R6 flags held", 32'(curFlags()), 32'(heldFl));

    // R4: normalize ignores expA, uses held result (4064) + 40 = 8
    opValid = 1'b1; opCode = 2'd2; expA = 12'd999; expB = 12'd40; cvtLong = 1'b0;
    @(negedge clk);
    chk("R4 feedback result", 32'(result), 8);
    chk("R2 shift zero for normalize", 32'(shiftAmt), 0);
    opValid = 1'b0;
    @(negedge clk);

    // R11 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 reset result", 32'(result), 0);
    chk("R11 reset valid", 32'(resValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule